// File: doc/BRIEF.md
# Hash Engine Register Front End

This block is the register-level front end of a combined MD5/SHA-1 hashing engine. Software drives it over a simple memory-mapped bus with 32-bit word addresses. A control register selects the algorithm, starts the engine and asks it to finish. Five IV registers hold chaining state saved from an earlier run, and five digest registers return the result. A receive FIFO accepts message words. A status register reports the free FIFO space, a sticky overflow flag, a digest-valid flag and a mirror of the finish request.

The compression rounds are not part of this block. A stub core stands in for them. It takes one queued word every `WORD_CYCLES` cycles and folds it into five 32-bit chaining lanes. After the finish request it spends `FIN_CYCLES` more cycles before it reports completion. When completion is reported, the finish bit clears. One cycle later the digest registers load and the digest-valid flag rises.

Register map (word addresses): 0 control, 1 status, 2 FIFO data (write only), 3..7 IV lanes 0..4, 8..12 digest lanes 0..4. Any other address reads zero.

Top module: `hash_ctl_frontend`

## Requirements
- R1: After reset the control register reads 0, and status reads `DEPTH` free slots with the overflow, valid and busy flags clear.
- R2: A control write with enable (bit 0) = 1 while the engine is disabled is a start. A start empties the FIFO (free slots = `DEPTH`), clears the overflow and digest-valid flags, and latches the algorithm bit (bit 1: 0 = MD5, 1 = SHA-1) and the resume bit (bit 2).
- R3: Writes to the FIFO data address while the engine is disabled are ignored. The free slot count stays at `DEPTH`.
- R4: When the resume bit is 0 at start, the chaining lanes start from the standard constants 67452301, EFCDAB89, 98BADCFE, 10325476 and, for SHA-1, C3D2E1F0. The IV registers are ignored.
- R5: When the resume bit is 1 at start, the chaining lanes start from IV registers 0..4.
- R6: Each accepted word w is absorbed in write order: every lane h becomes (h rotated left by one bit) XOR w. The core takes at most one word per `WORD_CYCLES` cycles, and the first word queued after a start is taken on the next cycle.
- R7: Writing control bit 3 (finish) while enabled sets it. It reads back as 1 until every queued word is absorbed and `FIN_CYCLES` more cycles have passed, and then it clears by itself.
- R8: The digest-valid flag (status bit 9) rises exactly one cycle after the finish bit clears. Status bit 10 mirrors the finish bit.
- R9: Digest lanes 0..4 are read at addresses 8..12. In MD5 mode digest lane 4 reads 0.
- R10: A FIFO write while the FIFO is full is dropped and sets the overflow flag (status bit 8). The flag stays set until the next start.
- R11: Writing 0 to the control register disables the engine: control reads 0, the FIFO is emptied, and digest-valid clears.
- R12: Status bits 7..0 report `DEPTH` minus the number of queued words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest state to reach from the ports is a full FIFO: the core keeps draining it, so the exact queue depth depends on how writes and absorptions interleave. The bench builds the block with a long word pacing. Exactly one word is then taken early, so back-to-back writes give an exact free-slot count, a predictable overflow point, and a known set of absorbed words that the final digest must reflect. The one-cycle gap between the finish bit clearing and the digest becoming valid is checked by polling status every cycle.

// File: rtl/hash_fe_pkg.sv
package hash_fe_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 5;
  localparam int ADDR_W  = 4;

  typedef logic [LANES-1:0][WORD_W-1:0] chain_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 4'd2;
  localparam logic [ADDR_W-1:0] A_IV0  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DIG0 = 4'd8;

  localparam int CB_EN     = 0;
  localparam int CB_SHA    = 1;
  localparam int CB_RESUME = 2;
  localparam int CB_FIN    = 3;

  localparam int SB_OVF   = 8;
  localparam int SB_VALID = 9;
  localparam int SB_BUSY  = 10;

  function automatic logic [WORD_W-1:0] std_init(input int k, input logic sha);
    case (k)
      0: return 32'h6745_2301;
      1: return 32'hEFCD_AB89;
      2: return 32'h98BA_DCFE;
      3: return 32'h1032_5476;
      default: return sha ? 32'hC3D2_E1F0 : 32'h0;
    endcase
  endfunction

  function automatic chain_t absorb(input chain_t h, input logic [WORD_W-1:0] w);
    chain_t r;
    for (int k = 0; k < LANES; k++) r[k] = {h[k][WORD_W-2:0], h[k][WORD_W-1]} ^ w;
    return r;
  endfunction

  function automatic logic [7:0] free_slots(input int depth, input int count);
    return 8'(depth - count);
  endfunction
endpackage

// File: rtl/hash_rx_fifo.sv
module hash_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hash_core_stub.sv
module hash_core_stub
  import hash_fe_pkg::*;
#(
  parameter int WORD_CYCLES = 4,
  parameter int FIN_CYCLES  = 8,
  localparam int CNTW = $clog2(WORD_CYCLES + 1),
  localparam int FW   = $clog2(FIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              sha,
  input  logic              resume,
  input  chain_t            iv,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] word,
  input  logic              finish_req,
  output logic              word_pop,
  output logic              done,
  output chain_t            chain
);
  logic [CNTW-1:0] gap;
  logic [FW-1:0]   fin_cnt;
  logic            fin_act;
  chain_t          init_val;

  for (genvar k = 0; k < LANES; k++) begin : g_init
    assign init_val[k] = resume ? iv[k] : std_init(k, sha);
  end

  assign word_pop = enable && !start && word_avail && (gap == '0) && !fin_act;
  assign done     = fin_act && (fin_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0; gap <= '0; fin_act <= 1'b0; fin_cnt <= '0;
    end else if (start) begin
      chain <= init_val; gap <= '0; fin_act <= 1'b0; fin_cnt <= '0;
    end else if (!enable) begin
      gap <= '0; fin_act <= 1'b0; fin_cnt <= '0;
    end else begin
      if (word_pop) begin
        chain <= absorb(chain, word);
        gap   <= CNTW'(WORD_CYCLES - 1);
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end
      if (fin_act) begin
        if (fin_cnt == '0) fin_act <= 1'b0;
        else               fin_cnt <= fin_cnt - 1'b1;
      end else if (finish_req && !word_avail && gap == '0) begin
        fin_act <= 1'b1;
        fin_cnt <= FW'(FIN_CYCLES - 1);
      end
    end
  end
endmodule

// File: rtl/hash_ctl_frontend.sv
module hash_ctl_frontend
  import hash_fe_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int WORD_CYCLES = 4,
  parameter int FIN_CYCLES  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  logic en_q, sha_q, res_q, fin_q, ovf_q, valid_q, done_d;
  chain_t iv_q, dig_q, chain;
  logic ctrl_wr, start_evt, stop_evt;
  logic fifo_push_req, fifo_push_ok, fifo_full, fifo_empty, core_pop, core_done;
  logic [CW-1:0] fifo_count;
  logic [WORD_W-1:0] fifo_head, status_word, dig_lane4;

  assign ctrl_wr       = bus_wr && (bus_addr == A_CTRL);
  assign start_evt     = ctrl_wr && bus_wdata[CB_EN] && !en_q;
  assign stop_evt      = ctrl_wr && !bus_wdata[CB_EN];
  assign fifo_push_req = bus_wr && (bus_addr == A_DATA) && en_q;
  assign fifo_push_ok  = fifo_push_req && !fifo_full;
  assign dig_lane4     = dig_q[LANES-1];

  hash_rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(start_evt || stop_evt),
    .push(fifo_push_req), .push_data(bus_wdata), .pop(core_pop),
    .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  hash_core_stub #(.WORD_CYCLES(WORD_CYCLES), .FIN_CYCLES(FIN_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .start(start_evt),
    .sha(bus_wdata[CB_SHA]), .resume(bus_wdata[CB_RESUME]), .iv(iv_q),
    .word_avail(!fifo_empty), .word(fifo_head), .finish_req(fin_q),
    .word_pop(core_pop), .done(core_done), .chain(chain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sha_q <= 1'b0; res_q <= 1'b0; fin_q <= 1'b0;
      ovf_q <= 1'b0; valid_q <= 1'b0; done_d <= 1'b0;
    end else begin
      done_d <= core_done && !start_evt && !stop_evt;
      if (start_evt) begin
        en_q  <= 1'b1;
        sha_q <= bus_wdata[CB_SHA];
        res_q <= bus_wdata[CB_RESUME];
      end else if (stop_evt) begin
        en_q <= 1'b0; sha_q <= 1'b0; res_q <= 1'b0;
      end
      if (start_evt || stop_evt)                     fin_q <= 1'b0;
      else if (ctrl_wr && bus_wdata[CB_FIN] && en_q) fin_q <= 1'b1;
      else if (core_done)                            fin_q <= 1'b0;
      if (start_evt)                                 ovf_q <= 1'b0;
      else if (fifo_push_req && fifo_full)           ovf_q <= 1'b1;
      if (start_evt || stop_evt)                     valid_q <= 1'b0;
      else if (done_d)                               valid_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iv_q[k]  <= '0;
        dig_q[k] <= '0;
      end else begin
        if (bus_wr && bus_addr == ADDR_W'(int'(A_IV0) + k)) iv_q[k] <= bus_wdata;
        if (done_d) dig_q[k] <= (k == LANES - 1 && !sha_q) ? '0 : chain[k];
      end
    end
  end

  assign status_word = {21'b0, fin_q, valid_q, ovf_q, free_slots(DEPTH, int'(fifo_count))};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)      bus_rdata = {28'b0, fin_q, res_q, sha_q, en_q};
    else if (bus_addr == A_STAT) bus_rdata = status_word;
    for (int k = 0; k < LANES; k++) begin
      if (bus_addr == ADDR_W'(int'(A_IV0) + k))  bus_rdata = iv_q[k];
      if (bus_addr == ADDR_W'(int'(A_DIG0) + k)) bus_rdata = dig_q[k];
    end
  end
endmodule

// File: rtl/hash_ctl_frontend_chk.sv
module hash_ctl_frontend_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          ctrl_wr,
  input logic          start_evt,
  input logic          fin_q,
  input logic          valid_q,
  input logic          ovf_q,
  input logic          sha_q,
  input logic          fifo_push_req,
  input logic          fifo_push_ok,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic [31:0]   dig_lane4
);
  // R8: digest becomes valid the cycle after the finish bit drops
  a_r8_valid_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fin_q) && en_q && !ctrl_wr) |=> valid_q);

  // R10: a push into a full queue raises the overflow flag
  a_r10_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_req && fifo_full) |=> ovf_q);

  // R10: overflow is sticky until a start
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !start_evt) |=> ovf_q);

  // R2: a start leaves the queue empty
  a_r2_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (fifo_count == '0));

  // R3: nothing enters the queue while disabled
  a_r3_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !fifo_push_ok);

  // R9: MD5 digest lane 4 is zero when valid
  a_r9_md5_lane4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !sha_q) |-> (dig_lane4 == 32'h0));

  // R12: queue occupancy never exceeds its depth
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
endmodule

bind hash_ctl_frontend hash_ctl_frontend_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .ctrl_wr(ctrl_wr), .start_evt(start_evt),
  .fin_q(fin_q), .valid_q(valid_q), .ovf_q(ovf_q), .sha_q(sha_q),
  .fifo_push_req(fifo_push_req), .fifo_push_ok(fifo_push_ok), .fifo_full(fifo_full),
  .fifo_count(fifo_count), .dig_lane4(dig_lane4)
);

// File: tb/test_hash_ctl_frontend.sv
module test_hash_ctl_frontend;
  localparam int DEPTH = 32;
  localparam int WCYC  = 64;
  localparam int FCYC  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hash_ctl_frontend #(.DEPTH(DEPTH), .WORD_CYCLES(WCYC), .FIN_CYCLES(FCYC)) i_hash_ctl_frontend (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // vector: [39] sha, [38] resume, [37:32] word count, [31:0] seed
  localparam logic [39:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd0, 32'h0000_0000},
    {1'b1, 1'b0, 6'd0, 32'h1111_2222},
    {1'b0, 1'b1, 6'd0, 32'h1234_5678},
    {1'b1, 1'b1, 6'd5, 32'hA5A5_0F0F},
    {1'b0, 1'b0, 6'd7, 32'h0BAD_F00D},
    {1'b1, 1'b0, 6'd3, 32'hDEAD_BEEF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
    return seed ^ (32'h9E37_79B9 * 32'(i + 1));
  endfunction

  function automatic logic [31:0] std_const(input int k, input bit sha);
    logic [31:0] t [5];
    t = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
    return (k == 4 && !sha) ? 32'h0 : t[k];
  endfunction

  task automatic wait_done(output logic [31:0] s);
    int guard = 0;
    do begin rd(4'd1, s); guard++; end while (s[10] && guard < 20000);
  endtask

  task automatic check_digest(input logic [31:0] e [5], input string tag);
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      rd(4'(8 + k), d);
      chk(d == e[k], tag, d, e[k]);
    end
  endtask

  task automatic run_vec(input logic [39:0] v);
    bit sha = v[39], res = v[38];
    int n = int'(v[37:32]);
    logic [31:0] seed = v[31:0];
    logic [31:0] s, c;
    logic [31:0] e [5];
    for (int k = 0; k < 5; k++) wr(4'(3 + k), seed + 32'h0101_0101 * 32'(k + 1));
    wr(4'd0, 32'h0);
    wr(4'd0, {29'b0, res, sha, 1'b1});
    rd(4'd1, s);
    chk(s[7:0] == 8'(DEPTH) && !s[9] && !s[8], "R2 start empties queue", s, 32'(DEPTH));
    for (int i = 0; i < n; i++) wr(4'd2, word_of(seed, i));
    wr(4'd0, {28'b0, 1'b1, res, sha, 1'b1});
    rd(4'd0, c);
    chk(c[3] == 1'b1, "R7 finish bit held", c, {28'b0, 1'b1, res, sha, 1'b1});
    wait_done(s);
    chk(s[10] == 1'b0 && s[9] == 1'b0, "R8 valid low when finish clears", s, 32'h0);
    rd(4'd1, s);
    chk(s[9] == 1'b1, "R8 valid one cycle later", s, 32'h200);
    for (int k = 0; k < 5; k++)
      e[k] = res ? seed + 32'h0101_0101 * 32'(k + 1) : std_const(k, sha);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 5; k++) e[k] = ((e[k] << 1) | (e[k] >> 31)) ^ word_of(seed, i);
    if (!sha) e[4] = 32'h0;
    check_digest(e, n == 0 ? (res ? "R5 resume lanes" : "R4 standard lanes") : "R6 absorbed lanes");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, c;
    logic [31:0] e [5];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd0, c);
    chk(c == 32'h0, "R1 reset control", c, 32'h0);
    rd(4'd1, s);
    chk(s == 32'(DEPTH), "R1 reset status", s, 32'(DEPTH));

    for (int i = 0; i < 3; i++) wr(4'd2, 32'hCAFE_0000 + 32'(i));
    rd(4'd1, s);
    chk(s[7:0] == 8'(DEPTH), "R3 disabled writes ignored", s, 32'(DEPTH));

    for (int v = 0; v < 6; v++) run_vec(VEC[v]);

    // queue depth and overflow: one word absorbed early, then none for WCYC cycles
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h1);
    for (int i = 0; i < 10; i++) wr(4'd2, word_of(32'h5555_AAAA, i));
    rd(4'd1, s);
    chk(s[7:0] == 8'(DEPTH - 9), "R12 free slots after burst", s, 32'(DEPTH - 9));
    chk(s[8] == 1'b0, "R10 no overflow yet", s, 32'(DEPTH - 9));
    for (int i = 10; i < 50; i++) wr(4'd2, word_of(32'h5555_AAAA, i));
    rd(4'd1, s);
    chk(s[7:0] == 8'd0 && s[8], "R10 full and overflow set", s, 32'h100);
    wr(4'd0, 32'h9);
    wait_done(s);
    chk(s[8] == 1'b1, "R10 overflow sticky", s, 32'h100);
    for (int k = 0; k < 5; k++) e[k] = std_const(k, 1'b0);
    for (int i = 0; i < 33; i++)
      for (int k = 0; k < 5; k++) e[k] = ((e[k] << 1) | (e[k] >> 31)) ^ word_of(32'h5555_AAAA, i);
    e[4] = 32'h0;
    rd(4'd1, s);
    check_digest(e, "R10 dropped words not absorbed");
    rd(4'd12, s);
    chk(s == 32'h0, "R9 md5 lane 4 zero", s, 32'h0);

    wr(4'd0, 32'h0);
    rd(4'd0, c);
    chk(c == 32'h0, "R11 disabled control", c, 32'h0);
    rd(4'd1, s);
    chk(s[9] == 1'b0 && s[7:0] == 8'(DEPTH), "R11 valid cleared queue empty", s, 32'(DEPTH));
    wr(4'd2, 32'h1234);
    rd(4'd1, s);
    chk(s[7:0] == 8'(DEPTH), "R11 R3 write after disable ignored", s, 32'(DEPTH));
    wr(4'd0, 32'h1);
    rd(4'd1, s);
    chk(s == 32'(DEPTH), "R2 start clears overflow", s, 32'(DEPTH));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule